// File: doc/BRIEF.md
# Timer Interrupt Flag-and-Mask Controller

This block gathers the interrupt events of a timer unit with 32 event sources. A one-cycle event pulse on a source latches that source's flag bit, and the bit stays set until software clears it. Each source also has a mask bit. A flag raises an interrupt only while its mask bit is 0. Software changes the mask through two write-one registers, one that sets bits and one that clears them. It clears flags through a third write-one register. Bits written as 0 leave their state as it was, so software never needs a read-modify-write.

The unmasked pending sources are merged into three level-sensitive parent interrupt lines. A parameter picks one of two fixed groupings.

- **Variant A** gives sources 0 and 1 a line each and shares the third line among all the rest.
- **Variant B** gives source 5 a line of its own, puts every other source on a second line, and leaves the third line low.

The flag word and the mask word can both be read back through a combinational read port.

Top module: `tmr_irq_collector`

Register addresses on the 3-bit write and read ports:

| Address | Register | Access |
|---|---|---|
| 0 | flag word | read only |
| 1 | mask word | read only |
| 2 | mask set | write one to set |
| 3 | mask clear | write one to clear |
| 4 | flag clear | write one to clear |

## Requirements
- R1: After reset every flag bit is 0, every mask bit is 1, and all three parent lines are low.
- R2: A 1 on bit i of `evtPulse` at a rising clock edge sets flag bit i. The flag then stays set, whatever `evtPulse` does later, until it is cleared through the flag-clear register.
- R3: A write to address 2 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to address 3 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to address 4 clears each flag bit whose data bit is 1 and leaves the other flag bits unchanged.
- R6: If an event and a flag-clear write hit the same bit at the same edge, that flag bit ends up set.
- R7: A source is pending when its flag bit is 1 and its mask bit is 0. A parent line is high exactly while at least one pending source is routed to it. A line follows a mask or flag change from the first output sample after that edge, and it holds its level for as long as the pending state lasts.
- R8: With `ROUTE_MODE` = 0, source 0 drives `irqOut[0]`, source 1 drives `irqOut[1]`, and sources 2 to 31 share `irqOut[2]`.
- R9: With `ROUTE_MODE` = 1, source 5 drives `irqOut[0]`, sources 0 to 4 and 6 to 31 share `irqOut[1]`, and `irqOut[2]` stays low.
- R10: Address 0 returns the flag word and address 1 returns the mask word. Addresses 5 to 7 read as 0. Writes to addresses 0, 1 and 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 32 | Per-source event pulses from the timer channels |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 3 | Register address of the write |
| wrData | input | 32 | Write data, one bit per source |
| rdAddr | input | 3 | Register address of the combinational read |
| rdData | output | 32 | Read data |
| irqOut | output | 3 | Level-sensitive parent interrupt lines |

## Verification
Two functions can meet on the same edge: an event pulse setting a flag bit, and a flag-clear write aimed at that same bit. The bench drives both in one cycle, with the clear mask covering both the colliding bit and a second bit that is already set. It then reads the flag word back. The colliding bit must still be set and the other bit must be cleared.

The bench drives a second instance with the other routing variant from the same inputs. After each mask or flag change it compares both instances' parent lines with the routing that R8 and R9 spell out.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

  // Register addresses; software decodes these, so the values are fixed.
  typedef enum logic [2:0] {
    REG_FLAG     = 3'd0,
    REG_MASK     = 3'd1,
    REG_MASK_SET = 3'd2,
    REG_MASK_CLR = 3'd3,
    REG_FLAG_CLR = 3'd4
  } regSel_e;

  // Strobes handed from the control decode to the datapath.
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic flagClr;
  } wrStrobe_t;

endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] ADDR_MASK_SET = ADDR_W'(REG_MASK_SET);
  localparam logic [ADDR_W-1:0] ADDR_MASK_CLR = ADDR_W'(REG_MASK_CLR);
  localparam logic [ADDR_W-1:0] ADDR_FLAG_CLR = ADDR_W'(REG_FLAG_CLR);

  // Only the three write-one addresses produce a strobe; everything else is dropped.
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      strobe.maskSet = (wrAddr == ADDR_MASK_SET);
      strobe.maskClr = (wrAddr == ADDR_MASK_CLR);
      strobe.flagClr = (wrAddr == ADDR_FLAG_CLR);
    end
  end

endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] pendVec
);

  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(REG_FLAG);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(REG_MASK);

  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] flagClrBits;

  assign flagClrBits = strobe.flagClr ? wrData : '0;

  // The clear is applied first and the event is OR-ed in after it,
  // so an event on the same edge keeps its flag set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~flagClrBits) | evtPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '1;
    else if (strobe.maskSet) maskQ <= maskQ | wrData;
    else if (strobe.maskClr) maskQ <= maskQ & ~wrData;
  end

  assign pendVec = flagQ & ~maskQ;

  always_comb begin
    if (rdAddr == ADDR_FLAG)      rdData = flagQ;
    else if (rdAddr == ADDR_MASK) rdData = maskQ;
    else                          rdData = '0;
  end

  // Every event bit lands in the flag word at the next edge (R2, R6).
  p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));

  // With no clear strobe, no flag bit drops (R2).
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.flagClr) |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // Mask-set forces the written ones to 1 (R3).
  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((maskQ & $past(wrData)) == $past(wrData)));

  // Mask-clear forces the written ones to 0 (R4).
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClr |=> ((maskQ & $past(wrData)) == '0));

  // With no mask strobe, the mask word is unchanged (R10).
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.maskSet && !strobe.maskClr) |=> $stable(maskQ));

  // Flag-clear zeroes written bits that had no event on the same edge (R5).
  p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagClr |=> ((flagQ & $past(wrData) & ~$past(evtPulse)) == '0));

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned ROUTE_MODE = 0,
  parameter int unsigned NUM_LINES  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   pendVec,
  output logic [NUM_LINES-1:0] irqOut
);

  generate
    if (ROUTE_MODE == 0) begin : g_split_low
      // Sources 0 and 1 get a line each; all the rest share the last line.
      assign irqOut = {|pendVec[NUM_SRC-1:2], pendVec[1], pendVec[0]};
    end else begin : g_solo_five
      // Source 5 gets a line of its own; every other source shares line 1.
      logic sharedHit;
      assign sharedHit = |{pendVec[NUM_SRC-1:6], pendVec[4:0]};
      assign irqOut    = {1'b0, sharedHit, pendVec[5]};
    end
  endgenerate

  // No line is raised without a pending source (R7).
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |-> (irqOut == '0));

  // Every source is routed somewhere, so pending work always shows (R7).
  p_pending_seen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec != '0) |-> (irqOut != '0));

endmodule

// File: rtl/tmr_irq_collector.sv
module tmr_irq_collector
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ROUTE_MODE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SRC-1:0] rdData,
  output logic [2:0]         irqOut
);

  localparam int unsigned NUM_LINES = 3;

  wrStrobe_t          strobe;
  logic [NUM_SRC-1:0] pendVec;

  tmr_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .strobe(strobe)
  );

  tmr_irq_regs #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .evtPulse(evtPulse),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .pendVec (pendVec)
  );

  tmr_irq_router #(
    .NUM_SRC   (NUM_SRC),
    .ROUTE_MODE(ROUTE_MODE),
    .NUM_LINES (NUM_LINES)
  ) u_router (
    .clk    (clk),
    .rstN   (rstN),
    .pendVec(pendVec),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tmr_irq_collector_bench.sv
module tmr_irq_collector_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtPulse = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData, rdDataB;
  logic [2:0]  irqA, irqB;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tmr_irq_collector #(.ROUTE_MODE(0)) u_tmr_irq_collector (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqA));

  tmr_irq_collector #(.ROUTE_MODE(1)) u_tmr_irq_collector_alt (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdDataB), .irqOut(irqB));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  // Drives one write for a single cycle; the state is updated by the next negedge.
  task automatic writeReg(logic [2:0] a, logic [31:0] d, logic [31:0] evt);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; evtPulse = evt;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtPulse = '0;
    #1;
  endtask

  task automatic pulse(logic [31:0] evt);
    @(negedge clk);
    evtPulse = evt;
    @(negedge clk);
    evtPulse = '0;
    #1;
  endtask

  task automatic expectState(string req, logic [31:0] f, logic [31:0] m,
                             logic [2:0] ia, logic [2:0] ib);
    logic [31:0] v;
    readReg(3'd0, v); check({req, " flags"}, v, f);
    readReg(3'd1, v); check({req, " mask"}, v, m);
    check({req, " irq variant A"}, {29'd0, irqA}, {29'd0, ia});
    check({req, " irq variant B"}, {29'd0, irqB}, {29'd0, ib});
  endtask

  task automatic testReset();
    expectState("R1 reset", 32'h0, 32'hFFFF_FFFF, 3'b000, 3'b000);
  endtask

  task automatic testEventsMasked();
    pulse(32'h0000_0021);
    // Events are latched but still masked, so R7 keeps the lines low.
    expectState("R2 R7 masked events", 32'h21, 32'hFFFF_FFFF, 3'b000, 3'b000);
    repeat (3) @(negedge clk);
    #1;
    expectState("R2 sticky", 32'h21, 32'hFFFF_FFFF, 3'b000, 3'b000);
  endtask

  task automatic testUnmask();
    writeReg(3'd3, 32'h0000_0001, '0);
    expectState("R4 R8 R9 unmask src0", 32'h21, 32'hFFFF_FFFE, 3'b001, 3'b010);
    writeReg(3'd3, 32'h0000_0020, '0);
    expectState("R4 R8 R9 unmask src5", 32'h21, 32'hFFFF_FFDE, 3'b101, 3'b011);
  endtask

  task automatic testRemask();
    writeReg(3'd2, 32'h0000_0001, '0);
    expectState("R3 R7 remask src0", 32'h21, 32'hFFFF_FFDF, 3'b100, 3'b001);
  endtask

  task automatic testFlagClear();
    writeReg(3'd4, 32'h0000_0020, '0);
    expectState("R5 R7 clear src5", 32'h01, 32'hFFFF_FFDF, 3'b000, 3'b000);
  endtask

  task automatic testCollision();
    // The clear covers bits 0 and 1; bit 1 gets an event on the same edge.
    writeReg(3'd4, 32'h0000_0003, 32'h0000_0002);
    expectState("R6 event beats clear", 32'h02, 32'hFFFF_FFDF, 3'b000, 3'b000);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    writeReg(3'd0, 32'h0000_0000, '0);
    writeReg(3'd1, 32'h0000_0000, '0);
    writeReg(3'd6, 32'hFFFF_FFFF, '0);
    writeReg(3'd7, 32'hFFFF_FFFF, '0);
    expectState("R10 writes ignored", 32'h02, 32'hFFFF_FFDF, 3'b000, 3'b000);
    readReg(3'd5, v); check("R10 addr5 reads 0", v, 32'h0);
    readReg(3'd7, v); check("R10 addr7 reads 0", v, 32'h0);
  endtask

  task automatic testHighSource();
    writeReg(3'd3, 32'h8000_0002, '0);
    expectState("R7 R8 R9 unmask src1", 32'h02, 32'h7FFF_FFDD, 3'b010, 3'b010);
    pulse(32'h8000_0000);
    expectState("R8 R9 src31 shared", 32'h8000_0002, 32'h7FFF_FFDD, 3'b110, 3'b010);
    repeat (5) @(negedge clk);
    #1;
    expectState("R7 level held", 32'h8000_0002, 32'h7FFF_FFDD, 3'b110, 3'b010);
    writeReg(3'd4, 32'h0000_0002, '0);
    expectState("R5 R8 partial clear", 32'h8000_0000, 32'h7FFF_FFDD, 3'b100, 3'b010);
    writeReg(3'd4, 32'hFFFF_FFFF, '0);
    expectState("R5 R7 all cleared", 32'h0, 32'h7FFF_FFDD, 3'b000, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testEventsMasked();
    testUnmask();
    testRemask();
    testFlagClear();
    testCollision();
    testReadOnly();
    testHighSource();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule